// File: doc/BRIEF.md
# Flush-to-Zero Scalar Float Multiplier

This block multiplies two scalar floating-point values held in a compact 24-bit encoding. From the top bit down, the word holds a sign bit, a 7-bit exponent and 16 explicit fraction bits. It follows the arithmetic conventions of a small shader core rather than IEEE 754. There is no negative zero. Subnormal operands and subnormal results are both flushed to +0. An infinity times a zero gives zero, while a NaN times a zero still gives NaN.

Each instance handles one vector component. Operands enter through a valid/ready handshake and the product leaves through a second valid/ready handshake a fixed number of cycles later. That number is set by a parameter to one or two register stages. With two stages, the significand product is registered before normalisation and rounding. The whole pipeline stalls as one unit while the output is held.

Top module: `ftz_fmul`

## Requirements
- R1: A word is {sign[23], exponent[22:16], fraction[15:0]} with exponent bias 63, so 1.0 is 0x3F0000. For two normal finite operands the result is the product rounded to a normal value in the same encoding, with sign equal to the XOR of the operand signs.
- R2: Rounding is round-to-nearest with ties going to the even fraction. A carry out of rounding raises the exponent by one.
- R3: An operand whose exponent field is 0 counts as +0 whatever its sign and fraction bits. Its product with any finite value or zero is 0x000000.
- R4: A result whose exponent after rounding would be 0 or below is flushed to 0x000000. Halving 1.0 sixty-two times gives 0x010000, and the sixty-third halving gives 0x000000.
- R5: Every zero result is encoded as 0x000000, including products of negative operands and negative values that underflow.
- R6: An operand with exponent field 127 and fraction 0 is infinity. Infinity times zero (or a subnormal) gives 0x000000. Infinity times a non-zero finite value or an infinity gives an infinity with the XOR sign (0x7F0000 or 0xFF0000).
- R7: An operand with exponent field 127 and a non-zero fraction is NaN. Any product with a NaN operand, including NaN times zero, gives the canonical NaN 0x7F8000.
- R8: A finite product whose rounded exponent reaches 127 or more gives an infinity with the XOR sign.
- R9: in_ready is high exactly when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, out_valid and out_res hold their values.
- R10: After reset out_valid and out_res are 0. With out_ready held high, an operand pair accepted at one clock edge appears on out_valid/out_res after exactly LATENCY clock edges, and results leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Pipeline can take an operand pair this cycle |
| in_a | input | 1+EXP_W+MAN_W | First operand |
| in_b | input | 1+EXP_W+MAN_W | Second operand |
| out_valid | output | 1 | out_res holds a product |
| out_ready | input | 1 | Consumer takes the product this cycle |
| out_res | output | 1+EXP_W+MAN_W | Rounded, flushed product |

## Verification
The bench builds two instances. The first is a reduced format with EXP_W=4, MAN_W=3 and LATENCY=2, small enough that all 65,536 operand pairs are streamed through it. That sweep reaches every rounding tie, every carry out of rounding, every underflow and overflow boundary and every special-operand pairing, and a second pass with a randomly throttled out_ready exercises stalls of the two-stage pipeline. The second instance uses the full 24-bit format with LATENCY=1. It takes the halving chain from 1.0, hand-picked ties, signed specials and a few thousand pseudo-random pairs, each compared against an integer model of rounding written in the bench.

// File: rtl/ftz_fmul_pkg.sv
package ftz_fmul_pkg;
   // Operand / result classification shared by all stages.
   typedef enum logic [1:0] {
      K_NUM  = 2'd0,
      K_ZERO = 2'd1,
      K_INF  = 2'd2,
      K_NAN  = 2'd3
   } fkind_e;
endpackage

// File: rtl/ftz_fmul_unpack.sv
module ftz_fmul_unpack
   import ftz_fmul_pkg::*;
#(
   parameter int EXP_W = 7,
   parameter int MAN_W = 16,
   localparam int W  = 1 + EXP_W + MAN_W,
   localparam int SW = MAN_W + 1
) (
   input  logic [W-1:0]     op,
   output logic             sgn,
   output fkind_e           kind,
   output logic [EXP_W-1:0] ex,
   output logic [SW-1:0]    sig
);
   logic [EXP_W-1:0] ef;
   logic [MAN_W-1:0] mf;

   assign sgn = op[W-1];
   assign ef  = op[W-2 -: EXP_W];
   assign mf  = op[MAN_W-1:0];
   assign ex  = ef;
   assign sig = {1'b1, mf};

   // Exponent 0 covers both zero and subnormal: both become +0.
   always_comb begin
      if (ef == '0)
         kind = K_ZERO;
      else if (&ef)
         kind = (mf == '0) ? K_INF : K_NAN;
      else
         kind = K_NUM;
   end
endmodule

// File: rtl/ftz_fmul_front.sv
module ftz_fmul_front
   import ftz_fmul_pkg::*;
#(
   parameter int EXP_W = 7,
   parameter int MAN_W = 16,
   localparam int SW = MAN_W + 1,
   localparam int PW = 2 * SW,
   localparam int XW = EXP_W + 2
) (
   input  fkind_e                  kind_a,
   input  fkind_e                  kind_b,
   input  logic                    sgn_a,
   input  logic                    sgn_b,
   input  logic [EXP_W-1:0]        ex_a,
   input  logic [EXP_W-1:0]        ex_b,
   input  logic [SW-1:0]           sig_a,
   input  logic [SW-1:0]           sig_b,
   output fkind_e                  kind,
   output logic                    sgn,
   output logic signed [XW-1:0]    exs,
   output logic [PW-1:0]           prod
);
   localparam logic signed [XW-1:0] BIAS_X = XW'((1 << (EXP_W - 1)) - 1);

   logic any_nan, any_inf, any_zero;

   assign any_nan  = (kind_a == K_NAN)  || (kind_b == K_NAN);
   assign any_inf  = (kind_a == K_INF)  || (kind_b == K_INF);
   assign any_zero = (kind_a == K_ZERO) || (kind_b == K_ZERO);

   // NaN dominates; infinity against a zero collapses to zero.
   always_comb begin
      if (any_nan)
         kind = K_NAN;
      else if (any_inf)
         kind = any_zero ? K_ZERO : K_INF;
      else if (any_zero)
         kind = K_ZERO;
      else
         kind = K_NUM;
   end

   assign sgn  = sgn_a ^ sgn_b;
   assign exs  = XW'(ex_a) + XW'(ex_b) - BIAS_X;
   assign prod = PW'(sig_a) * PW'(sig_b);
endmodule

// File: rtl/ftz_fmul_back.sv
module ftz_fmul_back
   import ftz_fmul_pkg::*;
#(
   parameter int EXP_W = 7,
   parameter int MAN_W = 16,
   localparam int W  = 1 + EXP_W + MAN_W,
   localparam int SW = MAN_W + 1,
   localparam int PW = 2 * SW,
   localparam int XW = EXP_W + 2
) (
   input  fkind_e               kind,
   input  logic                 sgn,
   input  logic signed [XW-1:0] exs,
   input  logic [PW-1:0]        prod,
   output logic [W-1:0]         res
);
   localparam logic signed [XW-1:0] EMAX_X = XW'((1 << EXP_W) - 1);
   localparam logic signed [XW-1:0] ZERO_X = '0;
   localparam logic [W-1:0] NAN_C = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   logic                 top;
   logic [PW-1:0]        norm;
   logic [SW-1:0]        kept;
   logic                 guard, sticky, rnd;
   logic [SW:0]          sum;
   logic signed [XW-1:0] adj, ef;
   logic                 unused_hidden;

   // Product of two [1,2) significands lies in [1,4): one-bit normalise.
   assign top    = prod[PW-1];
   assign norm   = top ? prod : {prod[PW-2:0], 1'b0};
   assign kept   = norm[PW-1 -: SW];
   assign guard  = norm[PW-1-SW];
   assign sticky = |norm[PW-2-SW:0];
   assign rnd    = guard & (sticky | kept[0]);
   assign sum    = {1'b0, kept} + (SW+1)'(rnd);
   assign adj    = XW'(top) + XW'(sum[SW]);
   assign ef     = exs + adj;
   assign unused_hidden = sum[MAN_W];

   always_comb begin
      unique case (kind)
         K_NAN:  res = NAN_C;
         K_INF:  res = {sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
         K_ZERO: res = '0;
         default: begin
            if (ef >= EMAX_X)
               res = {sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            else if (ef <= ZERO_X)
               res = '0;
            else
               res = {sgn, ef[EXP_W-1:0], sum[MAN_W-1:0]};
         end
      endcase
   end
endmodule

// File: rtl/ftz_fmul.sv
module ftz_fmul
   import ftz_fmul_pkg::*;
#(
   parameter int EXP_W   = 7,
   parameter int MAN_W   = 16,
   parameter int LATENCY = 2,
   localparam int W = 1 + EXP_W + MAN_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_a,
   input  logic [W-1:0] in_b,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_res
);
   localparam int SW = MAN_W + 1;
   localparam int PW = 2 * SW;
   localparam int XW = EXP_W + 2;
   localparam logic [W-1:0] NAN_C = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   generate
      if (LATENCY != 1 && LATENCY != 2) begin : g_bad_latency
         $error("ftz_fmul: LATENCY must be 1 or 2");
      end
      if (EXP_W < 3 || MAN_W < 2) begin : g_bad_format
         $error("ftz_fmul: EXP_W must be >= 3 and MAN_W >= 2");
      end
   endgenerate

   // Whole pipeline advances together whenever the output slot frees up.
   logic adv;
   assign adv      = !out_valid || out_ready;
   assign in_ready = adv;

   fkind_e             ka, kb;
   logic               sa, sb;
   logic [EXP_W-1:0]   ea, eb;
   logic [SW-1:0]      ma, mb;

   ftz_fmul_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack_a (
      .op(in_a), .sgn(sa), .kind(ka), .ex(ea), .sig(ma));
   ftz_fmul_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack_b (
      .op(in_b), .sgn(sb), .kind(kb), .ex(eb), .sig(mb));

   fkind_e               f_kind;
   logic                 f_sgn;
   logic signed [XW-1:0] f_exs;
   logic [PW-1:0]        f_prod;

   ftz_fmul_front #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_front (
      .kind_a(ka), .kind_b(kb), .sgn_a(sa), .sgn_b(sb),
      .ex_a(ea), .ex_b(eb), .sig_a(ma), .sig_b(mb),
      .kind(f_kind), .sgn(f_sgn), .exs(f_exs), .prod(f_prod));

   fkind_e               b_kind;
   logic                 b_sgn;
   logic signed [XW-1:0] b_exs;
   logic [PW-1:0]        b_prod;
   logic                 b_valid;
   logic [W-1:0]         b_res;

   generate
      if (LATENCY == 1) begin : g_one_stage
         assign b_kind  = f_kind;
         assign b_sgn   = f_sgn;
         assign b_exs   = f_exs;
         assign b_prod  = f_prod;
         assign b_valid = in_valid;

         // R10: an accepted pair lands on the output at the next edge.
         p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_ready) |=> out_valid);
      end else begin : g_two_stage
         fkind_e               kind_q;
         logic                 sgn_q;
         logic signed [XW-1:0] exs_q;
         logic [PW-1:0]        prod_q;
         logic                 vld_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               kind_q <= K_ZERO;
               sgn_q  <= 1'b0;
               exs_q  <= '0;
               prod_q <= '0;
               vld_q  <= 1'b0;
            end else if (adv) begin
               kind_q <= f_kind;
               sgn_q  <= f_sgn;
               exs_q  <= f_exs;
               prod_q <= f_prod;
               vld_q  <= in_valid;
            end
         end

         assign b_kind  = kind_q;
         assign b_sgn   = sgn_q;
         assign b_exs   = exs_q;
         assign b_prod  = prod_q;
         assign b_valid = vld_q;

         // R10: an accepted pair occupies the middle stage after one edge.
         p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_ready) |=> vld_q);
      end
   endgenerate

   ftz_fmul_back #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_back (
      .kind(b_kind), .sgn(b_sgn), .exs(b_exs), .prod(b_prod), .res(b_res));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_res   <= '0;
      end else if (adv) begin
         out_valid <= b_valid;
         out_res   <= b_res;
      end
   end

   // R5: a zero exponent on the output only ever appears as +0.
   p_plus_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_res[W-2 -: EXP_W] == '0) |-> (out_res == '0));

   // R7: any NaN leaving the block is the canonical one.
   p_nan_canon_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (&out_res[W-2 -: EXP_W]) && out_res[MAN_W-1:0] != '0)
      |-> (out_res == NAN_C));

   // R9: a refused result stays put.
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_res)));
endmodule

// File: tb/ftz_fmul_tb_top.sv
`timescale 1ns/1ps
module ftz_fmul_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;
   bit finished = 1'b0;

   // Small exhaustive instance: 1+4+3 bits, two stages.
   logic       s_in_valid = 1'b0, s_in_ready, s_out_valid, s_out_ready = 1'b1;
   logic [7:0] s_a = '0, s_b = '0, s_res;

   ftz_fmul #(.EXP_W(4), .MAN_W(3), .LATENCY(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(s_in_valid), .in_ready(s_in_ready),
      .in_a(s_a), .in_b(s_b), .out_valid(s_out_valid), .out_ready(s_out_ready),
      .out_res(s_res));

   // Full-width instance: 24 bits, one stage.
   logic        w_in_valid = 1'b0, w_in_ready, w_out_valid;
   logic [23:0] w_a = '0, w_b = '0, w_res;

   ftz_fmul #(.EXP_W(7), .MAN_W(16), .LATENCY(1)) dut_w_i (
      .clk(clk), .rst_n(rst_n), .in_valid(w_in_valid), .in_ready(w_in_ready),
      .in_a(w_a), .in_b(w_b), .out_valid(w_out_valid), .out_ready(1'b1),
      .out_res(w_res));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Bench model: integer significand product, RNE, flush, specials.
   function automatic logic [31:0] ref_mul(input int ew, input int mw,
                                           input logic [31:0] a, input logic [31:0] b);
      longint emax, bias, ea, eb, ma, mb, e, prod, q, rem, half, s;
      int msb, shift;
      bit na, nb, ia, ib, za, zb;
      emax = (longint'(1) << ew) - 1;
      bias = (longint'(1) << (ew - 1)) - 1;
      ea = (longint'(a) >> mw) & emax;
      eb = (longint'(b) >> mw) & emax;
      ma = longint'(a) & ((longint'(1) << mw) - 1);
      mb = longint'(b) & ((longint'(1) << mw) - 1);
      s  = longint'(a[ew+mw] ^ b[ew+mw]);
      na = (ea == emax) && (ma != 0);  nb = (eb == emax) && (mb != 0);
      ia = (ea == emax) && (ma == 0);  ib = (eb == emax) && (mb == 0);
      za = (ea == 0);                  zb = (eb == 0);
      if (na || nb) return 32'((emax << mw) | (longint'(1) << (mw - 1)));
      if (ia || ib) return (za || zb) ? 32'd0 : 32'((s << (ew + mw)) | (emax << mw));
      if (za || zb) return 32'd0;
      prod = (ma + (longint'(1) << mw)) * (mb + (longint'(1) << mw));
      e = ea + eb - bias;
      msb = ((prod >> (2*mw + 1)) != 0) ? 2*mw + 1 : 2*mw;
      e = e + (msb - 2*mw);
      shift = msb - mw;
      q = prod >> shift;
      rem = prod & ((longint'(1) << shift) - 1);
      half = longint'(1) << (shift - 1);
      if (rem > half || (rem == half && q[0])) q = q + 1;
      if (q == (longint'(2) << mw)) begin q = q >> 1; e = e + 1; end
      if (e >= emax) return 32'((s << (ew + mw)) | (emax << mw));
      if (e <= 0) return 32'd0;
      return 32'((s << (ew + mw)) | (e << mw) | (q & ((longint'(1) << mw) - 1)));
   endfunction

   function automatic string tag_of(input int ew, input int mw, input logic [31:0] a,
                                    input logic [31:0] b, input logic [31:0] exp);
      longint emax, ea, eb, ma, mb, ee;
      emax = (longint'(1) << ew) - 1;
      ea = (longint'(a) >> mw) & emax;  eb = (longint'(b) >> mw) & emax;
      ma = longint'(a) & ((longint'(1) << mw) - 1);
      mb = longint'(b) & ((longint'(1) << mw) - 1);
      ee = (longint'(exp) >> mw) & emax;
      if ((ea == emax && ma != 0) || (eb == emax && mb != 0)) return "R7";
      if (ea == emax || eb == emax) return "R6";
      if (ea == 0 || eb == 0) return "R3";
      if (exp == 0) return "R4";
      if (ee == emax) return "R8";
      return "R2";
   endfunction

   // Scoreboard for the small instance.
   logic [7:0] exp_q[$];
   string      tag_q[$];
   bit         stall_mode = 1'b0;
   bit         hold_pend = 1'b0;
   logic [7:0] hold_val = '0;
   logic [15:0] lfsr = 16'hACE1;

   always @(posedge clk) begin
      #2;
      if (stall_mode) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         s_out_ready = lfsr[0] | lfsr[3];
      end else begin
         s_out_ready = 1'b1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (hold_pend) begin
            chk("R9 held valid", 32'(s_out_valid), 32'd1);
            chk("R9 held result", 32'(s_res), 32'(hold_val));
         end
         hold_pend = s_out_valid && !s_out_ready;
         hold_val  = s_res;
         if (stall_mode)
            chk("R9 in_ready", 32'(s_in_ready), 32'(!s_out_valid || s_out_ready));
         if (s_out_valid && s_out_ready) begin
            if (exp_q.size() == 0) begin
               chk("R10 unexpected output", 32'(s_out_valid), 32'd0);
            end else begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(t, 32'(s_res), 32'(e));
            end
         end
      end
   end

   // Called at a falling edge; returns at the falling edge after acceptance.
   task automatic push(input logic [7:0] a, input logic [7:0] b);
      logic [31:0] e;
      s_in_valid = 1'b1;
      s_a = a;
      s_b = b;
      while (!s_in_ready) @(negedge clk);
      e = ref_mul(4, 3, 32'(a), 32'(b));
      exp_q.push_back(e[7:0]);
      tag_q.push_back(tag_of(4, 3, 32'(a), 32'(b), e));
      @(negedge clk);
   endtask

   task automatic wmul(input logic [23:0] a, input logic [23:0] b, input string tag,
                       input logic [23:0] exp, output logic [23:0] got);
      w_in_valid = 1'b1;
      w_a = a;
      w_b = b;
      @(negedge clk);
      w_in_valid = 1'b0;
      chk("R10 one-cycle valid", 32'(w_out_valid), 32'd1);
      chk(tag, 32'(w_res), 32'(exp));
      got = w_res;
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R10 actual=%0d expected=%0d", cycles, 150000);
         finish_run();
      end
   end

   initial begin
      logic [23:0] x, g;
      logic [31:0] wl;
      repeat (3) @(negedge clk);
      chk("R10 reset out_valid", 32'(s_out_valid), 32'd0);
      chk("R10 reset out_res", 32'(s_res), 32'd0);
      chk("R10 reset wide out_res", 32'(w_res), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: two-stage latency from an empty pipeline (1.0 * 1.0 = 0x38).
      push(8'h38, 8'h38);
      s_in_valid = 1'b0;
      chk("R10 not yet valid", 32'(s_out_valid), 32'd0);
      @(negedge clk);
      chk("R10 valid after two edges", 32'(s_out_valid), 32'd1);
      chk("R1 small one squared", 32'(s_res), 32'h38);
      @(negedge clk);

      // Exhaustive sweep of the small format (R2..R8 tagged per pair).
      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 256; b++)
            push(8'(a), 8'(b));
      s_in_valid = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);

      // R9: throttled consumer.
      stall_mode = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 400; i++)
         push(8'((i * 37 + 11) & 8'hFF), 8'((i * 101) ^ (i >> 2)));
      s_in_valid = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
      stall_mode = 1'b0;
      @(negedge clk);
      @(negedge clk);

      // Full-width directed cases.
      wmul(24'h3F0000, 24'h3F0000, "R1 one squared", 24'h3F0000, g);
      wmul(24'h3F8000, 24'h3F8000, "R1 1.5 squared", 24'h402000, g);
      wmul(24'hBF0000, 24'h3F0000, "R1 sign xor", 24'hBF0000, g);
      wmul(24'h3F0001, 24'h3F8000, "R2 tie rounds up to even", 24'h3F8002, g);
      wmul(24'h3F0003, 24'h3F8000, "R2 tie stays even", 24'h3F8004, g);
      wmul(24'h3F0002, 24'h3F8000, "R2 exact", 24'h3F8003, g);
      wmul(24'h80FFFF, 24'h400000, "R3 negative subnormal", 24'h000000, g);
      wmul(24'h3F0000, 24'h00FFFF, "R3 subnormal operand", 24'h000000, g);
      wmul(24'hBF0000, 24'h000000, "R5 minus one times zero", 24'h000000, g);
      wmul(24'h810000, 24'h010000, "R5 negative underflow", 24'h000000, g);
      wmul(24'h7F0000, 24'h000000, "R6 inf times zero", 24'h000000, g);
      wmul(24'hFF0000, 24'h00ABCD, "R6 inf times subnormal", 24'h000000, g);
      wmul(24'hFF0000, 24'h400000, "R6 negative inf", 24'hFF0000, g);
      wmul(24'hFF0000, 24'hFF0000, "R6 inf times inf", 24'h7F0000, g);
      wmul(24'h7F0001, 24'h000000, "R7 NaN times zero", 24'h7F8000, g);
      wmul(24'hFFFFFF, 24'h3F0000, "R7 negative NaN", 24'h7F8000, g);
      wmul(24'h7F0000, 24'h7F4000, "R7 inf times NaN", 24'h7F8000, g);
      wmul(24'h7EFFFF, 24'h7EFFFF, "R8 overflow", 24'h7F0000, g);
      wmul(24'h7EFFFF, 24'hFEFFFF, "R8 negative overflow", 24'hFF0000, g);

      // R4: halving chain from 1.0.
      x = 24'h3F0000;
      for (int k = 1; k <= 63; k++) begin
         wl = ref_mul(7, 16, 32'(x), 32'h3E0000);
         wmul(x, 24'h3E0000, "R1 halving step", wl[23:0], g);
         x = g;
         if (k == 62) chk("R4 smallest normal after 62 halvings", 32'(x), 32'h010000);
      end
      chk("R4 zero after 63 halvings", 32'(x), 32'h000000);

      // Pseudo-random full-width pairs.
      begin
         logic [31:0] r;
         r = 32'h1234_5678;
         for (int i = 0; i < 3000; i++) begin
            logic [23:0] a, b;
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            a = r[23:0];
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            b = r[23:0];
            if (i % 4 != 0) begin
               a[22:16] = 7'(32 + (r[29:24] % 60));
               b[22:16] = 7'(30 + (r[31:26] % 40));
            end
            wl = ref_mul(7, 16, 32'(a), 32'(b));
            wmul(a, b, tag_of(7, 16, 32'(a), 32'(b), wl), wl[23:0], g);
         end
      end

      finish_run();
   end
endmodule